// File: doc/BRIEF.md
# Receive-Path Latency Stamper

This block measures how long each packet spends crossing the receive path of a network card. One free-running cycle counter is shared by a set of probe points placed along the path, for example the input of the encapsulator, the output of the encapsulator, the start of the DMA and its completion. Each probe raises a strobe together with the tag of the packet passing it. The block records the counter value for that packet and that stage in a table indexed by tag.

The packet stream passes through the block. The samples for a packet are inserted into the packet itself, so the latency of every stage travels with the data. A static mode input selects one of two ways to do this. In trailer mode the samples are appended as extra words after the last beat of the packet. In patch mode the samples overwrite fixed word slots of a completion record, and the record keeps its length. Any latency is then the difference of two samples, taken modulo the counter range. With a 250 MHz counting clock, one count equals 4 ns.

Top module: `lat_profiler`

## Requirements
- R1: The cycle counter is CNT_W bits wide. It is zero after reset, adds one on every clock and wraps modulo 2^CNT_W. A sample taken at a clock edge holds the number of edges counted since reset, not including that edge.
- R2: A strobe on stage s (bit s of `stage_stb_i`, with its tag in bits s*TAG_W and up of `stage_tag_i`) records the sample for tag t and stage s. A later strobe for the same tag and stage replaces the earlier sample.
- R3: When `mode_patch_i` is 0, the last input beat is forwarded with `out_last_o` low. NSTAGE trailer words then follow in stage order 0 to NSTAGE-1. Each word holds its sample zero-extended in the low bits, and the final trailer word carries `out_last_o`.
- R4: A stage that has no sample for the packet's tag when its word is emitted is written as a word of all ones.
- R5: When `mode_patch_i` is 1, beats PATCH_OFS to PATCH_OFS+NSTAGE-1 of the packet (beat 0 is the first) are replaced by the samples of stages 0 to NSTAGE-1, in the same word format as R3. All other beats, and `out_last_o`, pass through unchanged, and no beat is added.
- R6: Once a packet has been fully emitted, every sample of its tag is discarded. A later packet that reuses the tag without new strobes gets all-ones words.
- R7: Outside trailer emission, `out_valid_o` equals `in_valid_i`, `in_ready_o` equals `out_ready_i`, and data beats pass unchanged in the same cycle. In trailer mode, `in_ready_o` is low only while the NSTAGE trailer words are pending. In patch mode it is never low on the block's account.
- R8: A packet's tag is taken from `in_tag_i` on its first beat. Up to 2^TAG_W packets with distinct tags may be in flight at once, and they keep separate samples.
- R9: After reset, no trailer is pending and the table holds no samples.
- R10: While `out_ready_i` is low, a trailer word stays on `out_data_o` with `out_valid_o` high until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counting and stream clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stage_stb_i | input | NSTAGE | One probe strobe per stage |
| stage_tag_i | input | NSTAGE*TAG_W | Packet tag of each probe, stage s in bits s*TAG_W and up |
| mode_patch_i | input | 1 | 0 appends a trailer, 1 patches a completion record; change only between packets |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Input beat accepted |
| in_data_i | input | DATA_W | Input beat data |
| in_last_i | input | 1 | Last beat of the input packet |
| in_tag_i | input | TAG_W | Packet tag, sampled on the first beat |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | DATA_W | Output beat data |
| out_last_o | output | 1 | Last beat of the output packet |

## Verification
The bench builds the block with an 8-bit counter, 16-bit data, four stages, a 2-bit tag and a patch offset of 1. The short counter wraps every 256 cycles, so a packet whose samples straddle the wrap can be tested directly. The four-entry table is small enough that every tag is occupied at once and then reused after it has been consumed. This exercises both the in-flight separation and the discard-on-emit behaviour. The vectors mix both insertion modes, full and partial stage masks, and packets shorter than the patch window.

// File: rtl/lat_prof_pkg.sv
package lat_prof_pkg;
  typedef enum logic {
    EMIT_DATA = 1'b0,
    EMIT_TRLR = 1'b1
  } emit_state_e;
endpackage

// File: rtl/lat_cycle_counter.sv
module lat_cycle_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/lat_sample_table.sv
module lat_sample_table #(
  parameter int NSTAGE = 4,
  parameter int TAG_W  = 3,
  parameter int CNT_W  = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NSTAGE-1:0]        stb_i,
  input  logic [NSTAGE*TAG_W-1:0]  stb_tag_i,
  input  logic [CNT_W-1:0]         cnt_i,
  input  logic                     clr_i,
  input  logic [TAG_W-1:0]         clr_tag_i,
  input  logic [TAG_W-1:0]         rd_tag_i,
  output logic [NSTAGE*CNT_W-1:0]  rd_sample_o,
  output logic [NSTAGE-1:0]        rd_valid_o
);
  localparam int DEPTH = 2 ** TAG_W;

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    logic [CNT_W-1:0] samp_q [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [TAG_W-1:0] wr_tag;

    assign wr_tag = stb_tag_i[s*TAG_W +: TAG_W];

    // a new sample wins over the clear of a consumed packet with the same tag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= '0;
      end else begin
        for (int e = 0; e < DEPTH; e++) begin
          if (stb_i[s] && wr_tag == TAG_W'(e))        vld_q[e] <= 1'b1;
          else if (clr_i && clr_tag_i == TAG_W'(e))  vld_q[e] <= 1'b0;
        end
      end
    end

    always_ff @(posedge clk_i) begin
      if (stb_i[s]) samp_q[wr_tag] <= cnt_i;
    end

    assign rd_sample_o[s*CNT_W +: CNT_W] = samp_q[rd_tag_i];
    assign rd_valid_o[s]                 = vld_q[rd_tag_i];
  end
endmodule

// File: rtl/lat_stream_inserter.sv
module lat_stream_inserter
  import lat_prof_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int CNT_W     = 32,
  parameter int NSTAGE    = 4,
  parameter int TAG_W     = 3,
  parameter int PATCH_OFS = 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    mode_patch_i,
  input  logic                    in_valid_i,
  output logic                    in_ready_o,
  input  logic [DATA_W-1:0]       in_data_i,
  input  logic                    in_last_i,
  input  logic [TAG_W-1:0]        in_tag_i,
  output logic                    out_valid_o,
  input  logic                    out_ready_i,
  output logic [DATA_W-1:0]       out_data_o,
  output logic                    out_last_o,
  output logic [TAG_W-1:0]        rd_tag_o,
  input  logic [NSTAGE*CNT_W-1:0] rd_sample_i,
  input  logic [NSTAGE-1:0]       rd_valid_i,
  output logic                    clr_o,
  output logic [TAG_W-1:0]        clr_tag_o
);
  localparam int SIDX_W = (NSTAGE > 1) ? $clog2(NSTAGE) : 1;
  localparam int BEAT_W = $clog2(PATCH_OFS + NSTAGE + 1);
  localparam logic [BEAT_W-1:0] BEAT_MAX  = BEAT_W'(PATCH_OFS + NSTAGE);
  localparam logic [BEAT_W-1:0] PATCH_LO  = BEAT_W'(PATCH_OFS);
  localparam logic [SIDX_W-1:0] LAST_WORD = SIDX_W'(NSTAGE - 1);

  emit_state_e       state_q;
  logic [SIDX_W-1:0] wcnt_q;
  logic [BEAT_W-1:0] beat_q;
  logic [TAG_W-1:0]  cur_tag_q;
  logic              sof_q;

  logic [DATA_W-1:0] stage_word [NSTAGE];
  logic [TAG_W-1:0]  tag_now;
  logic [BEAT_W-1:0] rel_beat;
  logic              patch_hit;
  logic              beat_acc;
  logic              trlr_done;

  for (genvar s = 0; s < NSTAGE; s++) begin : g_word
    assign stage_word[s] = rd_valid_i[s] ? DATA_W'(rd_sample_i[s*CNT_W +: CNT_W]) : '1;
  end

  assign tag_now   = sof_q ? in_tag_i : cur_tag_q;
  assign rd_tag_o  = (state_q == EMIT_TRLR) ? cur_tag_q : tag_now;
  assign rel_beat  = beat_q - PATCH_LO;
  assign patch_hit = mode_patch_i && (beat_q >= PATCH_LO) && (rel_beat < BEAT_W'(NSTAGE));

  always_comb begin
    if (state_q == EMIT_TRLR) begin
      in_ready_o  = 1'b0;
      out_valid_o = 1'b1;
      out_data_o  = stage_word[wcnt_q];
      out_last_o  = (wcnt_q == LAST_WORD);
    end else begin
      in_ready_o  = out_ready_i;
      out_valid_o = in_valid_i;
      out_data_o  = patch_hit ? stage_word[rel_beat[SIDX_W-1:0]] : in_data_i;
      out_last_o  = in_last_i && mode_patch_i;
    end
  end

  assign beat_acc  = (state_q == EMIT_DATA) && in_valid_i && out_ready_i;
  assign trlr_done = (state_q == EMIT_TRLR) && out_ready_i && (wcnt_q == LAST_WORD);
  assign clr_o     = (beat_acc && in_last_i && mode_patch_i) || trlr_done;
  assign clr_tag_o = rd_tag_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= EMIT_DATA;
      wcnt_q    <= '0;
      beat_q    <= '0;
      cur_tag_q <= '0;
      sof_q     <= 1'b1;
    end else if (state_q == EMIT_DATA) begin
      if (beat_acc) begin
        sof_q <= in_last_i;
        if (sof_q) cur_tag_q <= in_tag_i;
        if (in_last_i) begin
          beat_q <= '0;
          if (!mode_patch_i) begin
            state_q <= EMIT_TRLR;
            wcnt_q  <= '0;
          end
        end else if (beat_q != BEAT_MAX) begin
          beat_q <= beat_q + 1'b1;
        end
      end
    end else if (out_ready_i) begin
      wcnt_q <= wcnt_q + 1'b1;
      if (wcnt_q == LAST_WORD) state_q <= EMIT_DATA;
    end
  end
endmodule

// File: rtl/lat_profiler.sv
module lat_profiler #(
  parameter int DATA_W    = 64,
  parameter int CNT_W     = 32,
  parameter int NSTAGE    = 4,
  parameter int TAG_W     = 3,
  parameter int PATCH_OFS = 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NSTAGE-1:0]       stage_stb_i,
  input  logic [NSTAGE*TAG_W-1:0] stage_tag_i,
  input  logic                    mode_patch_i,
  input  logic                    in_valid_i,
  output logic                    in_ready_o,
  input  logic [DATA_W-1:0]       in_data_i,
  input  logic                    in_last_i,
  input  logic [TAG_W-1:0]        in_tag_i,
  output logic                    out_valid_o,
  input  logic                    out_ready_i,
  output logic [DATA_W-1:0]       out_data_o,
  output logic                    out_last_o
);
  logic [CNT_W-1:0]        cnt_q;
  logic [TAG_W-1:0]        rd_tag;
  logic [NSTAGE*CNT_W-1:0] rd_sample;
  logic [NSTAGE-1:0]       rd_valid;
  logic                    clr;
  logic [TAG_W-1:0]        clr_tag;

  lat_cycle_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt_q)
  );

  lat_sample_table #(.NSTAGE(NSTAGE), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_tbl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stb_i       (stage_stb_i),
    .stb_tag_i   (stage_tag_i),
    .cnt_i       (cnt_q),
    .clr_i       (clr),
    .clr_tag_i   (clr_tag),
    .rd_tag_i    (rd_tag),
    .rd_sample_o (rd_sample),
    .rd_valid_o  (rd_valid)
  );

  lat_stream_inserter #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .NSTAGE(NSTAGE), .TAG_W(TAG_W), .PATCH_OFS(PATCH_OFS)
  ) u_ins (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_patch_i (mode_patch_i),
    .in_valid_i   (in_valid_i),
    .in_ready_o   (in_ready_o),
    .in_data_i    (in_data_i),
    .in_last_i    (in_last_i),
    .in_tag_i     (in_tag_i),
    .out_valid_o  (out_valid_o),
    .out_ready_i  (out_ready_i),
    .out_data_o   (out_data_o),
    .out_last_o   (out_last_o),
    .rd_tag_o     (rd_tag),
    .rd_sample_i  (rd_sample),
    .rd_valid_i   (rd_valid),
    .clr_o        (clr),
    .clr_tag_o    (clr_tag)
  );
endmodule

// File: rtl/lat_profiler_chk.sv
module lat_profiler_chk #(
  parameter int NSTAGE = 4,
  parameter int CNT_W  = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_patch_i,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic             out_last_o,
  input logic [CNT_W-1:0] cnt_i
);
  logic        armed_q;
  logic [15:0] stall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      stall_q <= '0;
    end else begin
      armed_q <= 1'b1;
      if (in_ready_o)                       stall_q <= '0;
      else if (out_ready_i && stall_q != '1) stall_q <= stall_q + 1'b1;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> cnt_i == CNT_W'($past(cnt_i) + 1'b1)); // R1

  AST_TRLR_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_patch_i && out_valid_o && out_last_o) |-> !in_ready_o); // R3

  AST_BEAT_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |-> (out_valid_o && out_ready_i)); // R7

  AST_STALL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_q <= 16'(NSTAGE)); // R7
endmodule

bind lat_profiler lat_profiler_chk #(.NSTAGE(NSTAGE), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_patch_i (mode_patch_i),
  .in_valid_i   (in_valid_i),
  .in_ready_o   (in_ready_o),
  .out_valid_o  (out_valid_o),
  .out_ready_i  (out_ready_i),
  .out_last_o   (out_last_o),
  .cnt_i        (cnt_q)
);

// File: tb/lat_profiler_tb.sv
`timescale 1ns/1ps
module lat_profiler_tb;
  localparam int DW = 16, CW = 8, NS = 4, TW = 2, OFS = 1;
  localparam int NT = 2 ** TW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0] stb = '0;
  logic [NS*TW-1:0] stb_tag = '0;
  logic mode = 1'b0, in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic [DW-1:0] in_data = '0;
  logic [TW-1:0] in_tag = '0;
  logic in_ready, out_valid, out_last;
  logic [DW-1:0] out_data;
  logic [CW-1:0] bcnt;
  logic [CW-1:0] exp_samp [NT][NS];
  bit exp_vld [NT][NS];
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lat_profiler #(.DATA_W(DW), .CNT_W(CW), .NSTAGE(NS), .TAG_W(TW), .PATCH_OFS(OFS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .stage_stb_i(stb), .stage_tag_i(stb_tag),
    .mode_patch_i(mode), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .in_last_i(in_last), .in_tag_i(in_tag),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_last_o(out_last));

  // reference count per R1
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= '0; else bcnt <= bcnt + 1'b1;

  // mode, tag(2), len(3), mask(4)
  localparam logic [9:0] VEC [9] = '{
    {1'b0, 2'd0, 3'd3, 4'hF}, {1'b0, 2'd1, 3'd1, 4'hF}, {1'b0, 2'd2, 3'd4, 4'h5},
    {1'b1, 2'd3, 3'd6, 4'hF}, {1'b1, 2'd0, 3'd2, 4'hF}, {1'b1, 2'd1, 3'd3, 4'h0},
    {1'b0, 2'd0, 3'd2, 4'hA}, {1'b1, 2'd2, 3'd5, 4'h9}, {1'b0, 2'd3, 3'd1, 4'h0}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] exp_word(int t, int s);
    return exp_vld[t][s] ? DW'(exp_samp[t][s]) : '1;
  endfunction

  task automatic strobe(int s, int t);
    @(negedge clk);
    stb[s] = 1'b1;
    stb_tag[s*TW +: TW] = TW'(t);
    exp_samp[t][s] = bcnt;
    exp_vld[t][s] = 1'b1;
    @(posedge clk); #1;
    stb = '0;
  endtask

  task automatic send_pkt(input bit pm, input int t, input int len, input int stall_at, input string req);
    logic [DW-1:0] ev;
    @(negedge clk);
    mode = pm;
    for (int i = 0; i < len; i++) begin
      if (i > 0) @(negedge clk);
      in_valid = 1'b1; in_last = (i == len - 1); in_tag = TW'(t);
      in_data = DW'(16'h5A00 + t * 16 + i);
      #1;
      ev = in_data;
      if (pm && i >= OFS && i < OFS + NS) ev = exp_word(t, i - OFS);
      chk({req, " beat data"}, out_data, ev);
      chk({req, " R7 beat pass"}, {out_valid, in_ready}, 2'b11);
      chk({req, " beat last"}, out_last, in_last && pm);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    if (!pm) begin
      for (int s = 0; s < NS; s++) begin
        if (s > 0) @(negedge clk);
        if (s == stall_at) begin
          out_ready = 1'b0;
          for (int k = 0; k < 3; k++) begin
            #1;
            chk("R10 held word", {out_valid, in_ready, out_data}, {2'b10, exp_word(t, s)});
            @(negedge clk);
          end
          out_ready = 1'b1;
        end
        #1;
        chk({req, " R3 trailer word"}, out_data, exp_word(t, s));
        chk({req, " R7 trailer stall"}, {out_valid, in_ready, out_last}, {2'b10, s == NS - 1});
      end
      @(negedge clk); #1;
      chk("R7 ready after trailer", in_ready, 1'b1);
    end else begin
      #1;
      chk("R7 patch no stall", in_ready, 1'b1);
    end
    for (int s = 0; s < NS; s++) exp_vld[t][s] = 1'b0; // R6
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    for (int t = 0; t < NT; t++) for (int s = 0; s < NS; s++) exp_vld[t][s] = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R9 reset idle", {out_valid, in_ready}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);
    out_ready = 1'b0; #1;
    chk("R9 ready follows", in_ready, 1'b0);
    out_ready = 1'b1;
    send_pkt(1'b0, 1, 1, -1, "R9 empty table R4");

    for (int v = 0; v < 9; v++) begin
      for (int s = 0; s < NS; s++) if (VEC[v][s]) strobe(s, int'(VEC[v][8:7]));
      send_pkt(VEC[v][9], int'(VEC[v][8:7]), int'(VEC[v][6:4]), -1, "R2 R5");
    end

    // R8: all tags in flight at once
    for (int s = 0; s < NS; s++) for (int t = 0; t < NT; t++) strobe(s, t);
    for (int t = 0; t < NT; t++) send_pkt(1'b0, t, 2, -1, "R8");

    // R2 overwrite, R10 backpressure
    strobe(0, 2); strobe(2, 2); strobe(2, 2);
    send_pkt(1'b0, 2, 1, 1, "R2 overwrite");

    // R1 wrap
    while (bcnt != 8'hFD) @(negedge clk);
    for (int s = 0; s < NS; s++) strobe(s, 3);
    chk("R1 wrap model", {24'd0, exp_samp[3][3] - exp_samp[3][0]}, 32'd3);
    send_pkt(1'b0, 3, 2, -1, "R1 wrap");
    for (int s = 0; s < NS; s++) strobe(s, 0);
    send_pkt(1'b1, 0, 6, -1, "R1 R5 patch");

    // R6 reuse after consume
    send_pkt(1'b1, 0, 6, -1, "R6 reuse");
    done = 1;
    finish_run();
  end
endmodule